// File: doc/BRIEF.md
# Ethernet Group Indirect Register Bridge

This block gives a host register bus access to the registers of the sub-devices that make up one Ethernet group: a single wrapper, a set of PHYs, and an equal number of MACs. The host sees three 64-bit registers. One is a constant description of the group. One is a command word, and writing it starts exactly one read or write on a narrow downstream sub-device bus. The third is a status word that returns the captured read data together with a valid flag.

The downstream bus carries a 4-bit select code, a feature-space bit, a 16-bit register address and 32-bit write data. The sub-device ends each transfer with a one-cycle done pulse. The select code interleaves the targets: the wrapper uses code 0, PHY n uses code 2n+2 and MAC n uses code 2n+3. A code with no device behind it never reaches the bus. A built-in completion limit makes sure that a read always finishes well inside the host's 10 us polling window, even when the sub-device never answers.

Top module: `eg_bridge`

## Requirements
- R1: A read of byte offset 0x08 returns the group description: bits 7:0 the group number, bits 15:8 the PHY count (the MAC count is the same), bits 23:16 the speed in Gb/s, bit 24 the side flag, and zero in all bits above.
- R2: After reset the sub-device request is low, and reads of the status word (offset 0x18) and the command word (offset 0x10) both return zero.
- R3: A write to offset 0x10 with command bits 63:62 = 2 (write) or 1 (read) and a valid select raises the request on the next cycle. Bits 52:49 appear on the select output, bits 47:32 on the address and bits 31:0 on the write data, and the write flag is high only for command 2. All of these stay stable until the cycle in which done is sampled high; the request is low after that edge.
- R4: When done ends a read, bits 31:0 of the status word take the sub-device read data and bit 32 (valid) is set.
- R5: The feature-space output equals command bit 48 when the select code addresses a PHY (an even code from 2 to 2*PHY count). For the wrapper and for MACs it is forced to zero.
- R6: A select code of 1, or a code above the last MAC (2*PHY count + 1), produces no request. A read to such a code sets valid with data 0xFFFFFFFF at once, and a write to it is dropped.
- R7: An accepted read or write command clears the valid flag while the status data is held. A command of 0 (no-op) or 3 (reserved) leaves the status and the command word unchanged.
- R8: A command written while a transfer is still outstanding is ignored. The request fields and the command word read-back stay as they were, and no second transfer follows.
- R9: A read of the command word returns the fields of the last accepted command, with bits 63:62 always reading 0 (no-op) and bits 61:53 reading 0.
- R10: If done has not arrived after TIMEOUT_CYCLES cycles of request, the request drops. A timed-out read sets valid with data 0xFFFFFFFF.
- R11: Reads of any other offset return zero. Writes to offsets 0x08 and 0x18 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe; data returned on the next cycle |
| reg_addr | input | HOST_AW | Host byte offset |
| reg_wdata | input | 64 | Host write data |
| reg_rdata | output | 64 | Registered host read data |
| sd_req | output | 1 | Sub-device transfer outstanding |
| sd_write | output | 1 | 1 = write, 0 = read |
| sd_sel | output | 4 | Interleaved device select code |
| sd_feat | output | 1 | Feature-space select (PHY targets only) |
| sd_addr | output | 16 | Sub-device register address |
| sd_wdata | output | 32 | Sub-device write data |
| sd_done | input | 1 | One-cycle completion pulse from the sub-device |
| sd_rdata | input | 32 | Sub-device read data, valid with done |

## Verification
The assertions assume that the sub-device raises done for a single cycle and only while a request is outstanding, and that read data is meaningful only in that cycle. The bench acts as the sub-device and follows that rule. It drives done for exactly one cycle after it has observed the request, or leaves done low on purpose to reach the completion limit. Host strobes are driven one at a time between clock edges, so every command reaches the bridge as a single-cycle write.

// File: rtl/eg_bridge_pkg.sv
package eg_bridge_pkg;

  // host register byte offsets
  localparam int OFF_INFO = 8'h08;
  localparam int OFF_CTRL = 8'h10;
  localparam int OFF_STAT = 8'h18;

  // command word layout
  localparam int CMD_HI   = 63;
  localparam int CMD_LO   = 62;
  localparam int SEL_HI   = 52;
  localparam int SEL_LO   = 49;
  localparam int FEAT_BIT = 48;
  localparam int ADR_HI   = 47;
  localparam int ADR_LO   = 32;

  localparam int SEL_W  = 4;
  localparam int SADR_W = 16;
  localparam int SDAT_W = 32;

  // bits kept in the command word read-back
  localparam logic [63:0] CTRL_KEEP = 64'h001F_FFFF_FFFF_FFFF;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_READ = 2'd1,
    OP_WRITE= 2'd2,
    OP_RSVD = 2'd3
  } eg_op_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_WRAP = 2'd1,
    TGT_PHY  = 2'd2,
    TGT_MAC  = 2'd3
  } eg_tgt_e;

  typedef struct packed {
    logic              write;
    logic [SEL_W-1:0]  sel;
    logic              feat;
    logic [SADR_W-1:0] addr;
    logic [SDAT_W-1:0] wdata;
  } eg_req_t;

endpackage

// File: rtl/eg_sel_decode.sv
module eg_sel_decode
  import eg_bridge_pkg::*;
#(
  parameter int NUM_PHY = 4
) (
  input  logic [SEL_W-1:0] sel_i,
  output eg_tgt_e          tgt_o
);
  localparam int PAIR_W    = SEL_W - 1;
  localparam int MAX_PAIRS = (1 << PAIR_W) - 1;

  logic [PAIR_W-1:0] pair;
  logic              in_range;

  assign pair = sel_i[SEL_W-1:1];

  generate
    if (NUM_PHY >= MAX_PAIRS) begin : g_full
      assign in_range = (pair != '0);
    end else begin : g_part
      assign in_range = (pair != '0) && (pair <= PAIR_W'(NUM_PHY));
    end
  endgenerate

  always_comb begin
    if (sel_i == '0)      tgt_o = TGT_WRAP;
    else if (!in_range)   tgt_o = TGT_NONE;
    else if (sel_i[0])    tgt_o = TGT_MAC;
    else                  tgt_o = TGT_PHY;
  end

endmodule

// File: rtl/eg_host_regs.sv
module eg_host_regs
  import eg_bridge_pkg::*;
#(
  parameter int          HOST_AW   = 8,
  parameter logic [63:0] INFO_WORD = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [HOST_AW-1:0] reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  input  logic               busy_i,
  input  logic               st_valid_i,
  input  logic [SDAT_W-1:0]  st_data_i,
  output logic               start_o
);
  logic [63:0] ctrl_q;
  logic        hit_ctrl;
  eg_op_e      op;

  assign hit_ctrl = (reg_addr == HOST_AW'(OFF_CTRL));
  assign op       = eg_op_e'(reg_wdata[CMD_HI:CMD_LO]);
  assign start_o  = reg_wr && hit_ctrl && !busy_i &&
                    ((op == OP_READ) || (op == OP_WRITE));

  // command word shadow: only accepted commands update it
  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (start_o) ctrl_q <= reg_wdata & CTRL_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_addr == HOST_AW'(OFF_INFO))      reg_rdata <= INFO_WORD;
      else if (hit_ctrl)                       reg_rdata <= ctrl_q;
      else if (reg_addr == HOST_AW'(OFF_STAT)) reg_rdata <= {31'd0, st_valid_i, st_data_i};
      else                                     reg_rdata <= '0;
    end
  end

  // R9
  cmd_reads_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && hit_ctrl) |=> (reg_rdata[63:53] == '0));

endmodule

// File: rtl/eg_txn_engine.sv
module eg_txn_engine
  import eg_bridge_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              start_ok_i,
  input  eg_req_t           req_i,
  input  logic              sd_done_i,
  input  logic [SDAT_W-1:0] sd_rdata_i,
  output logic              busy_o,
  output eg_req_t           hold_o,
  output logic              st_valid_o,
  output logic [SDAT_W-1:0] st_data_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  typedef enum logic {S_IDLE, S_WAIT} state_e;

  state_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic            expire;

  assign busy_o = (state_q == S_WAIT);
  assign expire = busy_o && !sd_done_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      hold_o     <= '0;
      st_valid_o <= 1'b0;
      st_data_o  <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            st_valid_o <= 1'b0;
            cnt_q      <= '0;
            if (start_ok_i) begin
              hold_o  <= req_i;
              state_q <= S_WAIT;
            end else if (!req_i.write) begin
              st_valid_o <= 1'b1;
              st_data_o  <= '1;
            end
          end
        end
        default: begin
          if (sd_done_i) begin
            state_q <= S_IDLE;
            if (!hold_o.write) begin
              st_valid_o <= 1'b1;
              st_data_o  <= sd_rdata_i;
            end
          end else if (expire) begin
            state_q <= S_IDLE;
            if (!hold_o.write) begin
              st_valid_o <= 1'b1;
              st_data_o  <= '1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !sd_done_i && !expire) |=> (busy_o && $stable(hold_o)));

  // R3
  req_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && sd_done_i) |=> !busy_o);

  // R10
  limit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(sd_done_i) || $past(cnt_q) == LAST));

  // R7
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_valid_o) |-> ($past(start_i) || $past(busy_o)));

endmodule

// File: rtl/eg_bridge.sv
module eg_bridge
  import eg_bridge_pkg::*;
#(
  parameter int HOST_AW        = 8,
  parameter int NUM_PHY        = 4,
  parameter int GROUP_ID       = 0,
  parameter int SPEED_GBPS     = 10,
  parameter int DIRECTION      = 0,
  parameter int TIMEOUT_CYCLES = 2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [HOST_AW-1:0] reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               sd_req,
  output logic               sd_write,
  output logic [3:0]         sd_sel,
  output logic               sd_feat,
  output logic [15:0]        sd_addr,
  output logic [31:0]        sd_wdata,
  input  logic               sd_done,
  input  logic [31:0]        sd_rdata
);
  localparam logic [63:0] INFO_WORD = {39'd0, 1'(DIRECTION), 8'(SPEED_GBPS),
                                       8'(NUM_PHY), 8'(GROUP_ID)};

  logic              busy;
  logic              start;
  logic              st_valid;
  logic [SDAT_W-1:0] st_data;
  eg_tgt_e           tgt;
  eg_req_t           new_req;
  eg_req_t           hold;

  eg_sel_decode #(.NUM_PHY(NUM_PHY)) u_dec (
    .sel_i (reg_wdata[SEL_HI:SEL_LO]),
    .tgt_o (tgt)
  );

  always_comb begin
    new_req.write = (reg_wdata[CMD_HI:CMD_LO] == OP_WRITE);
    new_req.sel   = reg_wdata[SEL_HI:SEL_LO];
    new_req.feat  = reg_wdata[FEAT_BIT] && (tgt == TGT_PHY);
    new_req.addr  = reg_wdata[ADR_HI:ADR_LO];
    new_req.wdata = reg_wdata[SDAT_W-1:0];
  end

  eg_host_regs #(.HOST_AW(HOST_AW), .INFO_WORD(INFO_WORD)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy_i     (busy),
    .st_valid_i (st_valid),
    .st_data_i  (st_data),
    .start_o    (start)
  );

  eg_txn_engine #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .start_ok_i (tgt != TGT_NONE),
    .req_i      (new_req),
    .sd_done_i  (sd_done),
    .sd_rdata_i (sd_rdata),
    .busy_o     (busy),
    .hold_o     (hold),
    .st_valid_o (st_valid),
    .st_data_o  (st_data)
  );

  assign sd_req   = busy;
  assign sd_write = hold.write;
  assign sd_sel   = hold.sel;
  assign sd_feat  = hold.feat;
  assign sd_addr  = hold.addr;
  assign sd_wdata = hold.wdata;

  // R5
  feat_phy_only_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_req && sd_feat) |-> (sd_sel != 4'd0 && !sd_sel[0]));

  // R6
  sel_exists_chk: assert property (@(posedge clk) disable iff (rst)
    sd_req |-> (sd_sel == 4'd0 || (sd_sel >= 4'd2 && 32'(sd_sel[3:1]) <= NUM_PHY)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_req && !sd_done && reg_wr) |=> $stable(sd_sel));

endmodule

// File: tb/eg_bridge_test.sv
module eg_bridge_test;
  localparam int T_LIM = 32;

  typedef struct packed {
    logic [1:0]  cmd;
    logic [3:0]  sel;
    logic        feat;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] resp;
    logic        exp_req;
    logic        exp_feat;
  } vec_t;

  // bench instance has 2 PHYs: valid codes 0,2,3,4,5
  localparam vec_t VECS [0:9] = '{
    '{2'd2, 4'd2,  1'b1, 16'h1234, 32'hDEADBEEF, 32'h0,        1'b1, 1'b1},
    '{2'd1, 4'd5,  1'b1, 16'h0040, 32'h0,        32'hA5A50001, 1'b1, 1'b0},
    '{2'd1, 4'd0,  1'b1, 16'h0008, 32'h0,        32'h11112222, 1'b1, 1'b0},
    '{2'd1, 4'd4,  1'b0, 16'h00FF, 32'h0,        32'h33334444, 1'b1, 1'b0},
    '{2'd1, 4'd4,  1'b1, 16'h0100, 32'h0,        32'h55556666, 1'b1, 1'b1},
    '{2'd1, 4'd1,  1'b0, 16'h0001, 32'h0,        32'h0,        1'b0, 1'b0},
    '{2'd1, 4'd6,  1'b1, 16'h0002, 32'h0,        32'h0,        1'b0, 1'b0},
    '{2'd2, 4'd15, 1'b0, 16'h0003, 32'h12345678, 32'h0,        1'b0, 1'b0},
    '{2'd2, 4'd3,  1'b1, 16'hBEEF, 32'hCAFEF00D, 32'h0,        1'b1, 1'b0},
    '{2'd1, 4'd3,  1'b0, 16'h7777, 32'h0,        32'h0BADF00D, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        sd_req, sd_write, sd_feat;
  logic [3:0]  sd_sel;
  logic [15:0] sd_addr;
  logic [31:0] sd_wdata;
  logic        sd_done = 1'b0;
  logic [31:0] sd_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] model_data = '0;
  logic        model_valid = 1'b0;

  always #2.5 clk = ~clk;

  eg_bridge #(.HOST_AW(8), .NUM_PHY(2), .GROUP_ID(1), .SPEED_GBPS(25),
              .DIRECTION(1), .TIMEOUT_CYCLES(T_LIM)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_req(sd_req), .sd_write(sd_write),
    .sd_sel(sd_sel), .sd_feat(sd_feat), .sd_addr(sd_addr), .sd_wdata(sd_wdata),
    .sd_done(sd_done), .sd_rdata(sd_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: all requirements, actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_done(input logic [31:0] r);
    sd_done = 1'b1; sd_rdata = r;
    @(negedge clk);
    sd_done = 1'b0; sd_rdata = '0;
  endtask

  function automatic logic [63:0] word(input logic [1:0] c, input logic [3:0] s,
                                       input logic f, input logic [15:0] a,
                                       input logic [31:0] w);
    return {c, 9'd0, s, f, a, w};
  endfunction

  initial begin
    logic [63:0] rd;
    logic [63:0] ctrl_exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    chk("R2 req after reset", {63'd0, sd_req}, 64'd0);
    host_read(8'h18, rd); chk("R2 status after reset", rd, 64'd0);
    host_read(8'h10, rd); chk("R2 command after reset", rd, 64'd0);
    // R1 info word
    host_read(8'h08, rd); chk("R1 info word", rd, 64'h0000_0000_0119_0201);

    // vector table
    for (int i = 0; i < 10; i++) begin
      vec_t v = VECS[i];
      host_write(8'h10, word(v.cmd, v.sel, v.feat, v.addr, v.wdata));
      if (v.exp_req) begin
        chk("R3 request raised", {63'd0, sd_req}, 64'd1);
        chk("R3 fields", {11'd0, sd_write, sd_sel, sd_addr, sd_wdata},
            {11'd0, (v.cmd == 2'd2), v.sel, v.addr, v.wdata});
        chk("R5 feature output", {63'd0, sd_feat}, {63'd0, v.exp_feat});
        repeat (3) @(negedge clk);
        chk("R3 held until done", {10'd0, sd_req, sd_write, sd_sel, sd_addr, sd_wdata},
            {10'd0, 1'b1, (v.cmd == 2'd2), v.sel, v.addr, v.wdata});
        pulse_done(v.resp);
        chk("R3 request dropped after done", {63'd0, sd_req}, 64'd0);
      end else begin
        chk("R6 no request for missing target", {63'd0, sd_req}, 64'd0);
      end
      if (v.cmd == 2'd1) begin
        model_valid = 1'b1;
        model_data  = v.exp_req ? v.resp : 32'hFFFF_FFFF;
      end else begin
        model_valid = 1'b0;
      end
      host_read(8'h18, rd);
      chk(v.exp_req ? "R4 R7 status" : "R6 R7 status", rd,
          {31'd0, model_valid, model_data});
      host_read(8'h10, rd);
      chk("R9 command read-back", rd, {11'd0, v.sel, v.feat, v.addr, v.wdata});
    end

    // R8 command while busy
    host_write(8'h10, word(2'd1, 4'd2, 1'b0, 16'h0001, 32'h0));
    host_write(8'h10, word(2'd2, 4'd3, 1'b1, 16'h0002, 32'h99));
    chk("R8 busy write ignored", {43'd0, sd_req, sd_write, sd_sel, sd_addr},
        {43'd0, 1'b1, 1'b0, 4'd2, 16'h0001});
    pulse_done(32'h0000_BEEF);
    repeat (3) @(negedge clk);
    chk("R8 no second transfer", {63'd0, sd_req}, 64'd0);
    host_read(8'h18, rd); chk("R8 R4 status", rd, 64'h1_0000_BEEF);
    ctrl_exp = {11'd0, 4'd2, 1'b0, 16'h0001, 32'h0};
    host_read(8'h10, rd); chk("R8 command unchanged", rd, ctrl_exp);

    // R7 no-op and reserved leave everything
    host_write(8'h10, word(2'd0, 4'd4, 1'b1, 16'h4444, 32'h4));
    host_write(8'h10, word(2'd3, 4'd4, 1'b1, 16'h4444, 32'h4));
    chk("R7 no request on no-op", {63'd0, sd_req}, 64'd0);
    host_read(8'h18, rd); chk("R7 status kept", rd, 64'h1_0000_BEEF);
    host_read(8'h10, rd); chk("R7 command kept", rd, ctrl_exp);

    // R11 unmapped and read-only offsets
    host_read(8'h20, rd); chk("R11 unmapped reads zero", rd, 64'd0);
    host_write(8'h18, 64'hFFFF_FFFF_FFFF_FFFF);
    host_write(8'h08, 64'h0);
    chk("R11 no request", {63'd0, sd_req}, 64'd0);
    host_read(8'h18, rd); chk("R11 status not writable", rd, 64'h1_0000_BEEF);
    host_read(8'h08, rd); chk("R11 info not writable", rd, 64'h0000_0000_0119_0201);

    // R10 completion limit
    host_write(8'h10, word(2'd1, 4'd4, 1'b0, 16'h0055, 32'h0));
    host_read(8'h18, rd); chk("R7 valid cleared on read start", rd, 64'h0_0000_BEEF);
    repeat (T_LIM - 3) @(negedge clk);
    chk("R10 request before limit", {63'd0, sd_req}, 64'd1);
    @(negedge clk);
    chk("R10 request dropped at limit", {63'd0, sd_req}, 64'd0);
    host_read(8'h18, rd); chk("R10 timed-out read", rd, 64'h1_FFFF_FFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule